// File: doc/BRIEF.md
# E1 Per-Timeslot Idle Code Inserter

This block sits in the serial transmit path of an E1 framer. It follows the frame position itself, as 32 timeslots of 8 bits each. The position is aligned by a one-clock frame-sync pulse and runs freely between pulses. For every timeslot, a per-channel mask bit and a global mode bit choose where each outgoing bit comes from. It can be the transmit serial input, the receive serial input (a per-channel loopback) or a programmable 8-bit idle byte that is shifted out most significant bit first.

Software programs the block through a small synchronous byte-wide register port. Four mask registers together hold one bit per timeslot, one register holds the idle byte and one register holds the mode bit. The selection settings are captured on the first bit of every timeslot. A write that lands in the middle of a timeslot therefore takes effect from the next timeslot, and no byte on the line ever mixes old and new settings. The serial output is registered, so it lags the serial inputs by exactly one bit clock.

Top module: `e1_idle_inserter`

## Requirements
- R1: Without a frame-sync pulse, the frame position advances by one bit per clock through 8 bits per timeslot and 32 timeslots, and wraps from timeslot 31 bit 7 to timeslot 0 bit 0, i.e. every 256 clocks.
- R2: A cycle in which `fsync` is 1 is treated as bit 0 (the most significant bit) of timeslot 0, whatever the previous position was; the following cycles count on from there.
- R3: The mask bit for timeslot n (channel n+1) is bit n mod 8 of the mask register at address 0x26 + n/8: 0x26 covers timeslots 0..7, 0x27 covers 8..15, 0x28 covers 16..23 and 0x29 covers 24..31.
- R4: With the mode bit at 0, a timeslot whose mask bit is 1 carries the idle byte from address 0x2A, with bit 7 sent in bit position 0 of the timeslot and bit 0 sent in bit position 7.
- R5: With the mode bit at 0, a timeslot whose mask bit is 0 carries `tx_ser_in` unchanged.
- R6: With the mode bit (address 0x2B, bit 0) at 1, a timeslot whose mask bit is 1 carries `rx_ser_in` and a timeslot whose mask bit is 0 carries `tx_ser_in`; the idle byte is never sent in this mode.
- R7: After reset, all mask bits, the idle byte and the mode bit are 0, so every timeslot carries `tx_ser_in`.
- R8: `ser_out` in a cycle equals the bit selected from the inputs and settings of the previous cycle (one clock of latency).
- R9: The mask bit, idle byte and mode bit used for a timeslot are the register values present in that timeslot's bit-0 cycle; writes during bits 1..7 affect only later timeslots.
- R10: A read (`reg_re`=1) updates `reg_rdata` one clock later. The value is the last byte written for 0x26..0x2A, {7'b0, mode} for 0x2B and 0 for any other address. Without a read, `reg_rdata` holds its value. A read and a write in the same cycle return the value from before the write.
- R11: During reset, `ser_out` and `reg_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse marking timeslot 0, bit 0 |
| tx_ser_in | input | 1 | Transmit serial data |
| rx_ser_in | input | 1 | Receive serial data for per-channel loopback |
| ser_out | output | 1 | Registered outgoing serial data |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_rdata | output | 8 | Registered read data |

## Verification
The hardest case to reach from the ports is a settings write that lands strictly inside a timeslot. It must leave the rest of that byte untouched and then take effect cleanly at the next boundary, whether the write changes the mask, the idle byte or the mode. The bench gets there with a long phase of writes at random times and with random data across all six registers, combined with random serial data on both inputs. A behavioural model captures the settings only at each bit-0 position and is compared with the output on every clock, so every write offset within a byte is hit many times. Frame-sync pulses are also placed at arbitrary positions, so that realignment falls in the middle of a byte.

// File: rtl/e1ii_pkg.sv
package e1ii_pkg;
    localparam int E1_SLOTS     = 32;
    localparam int E1_SLOT_BITS = 8;
    localparam int REG_ADDR_W   = 8;

    localparam logic [REG_ADDR_W-1:0] MASK_BASE_ADDR = 8'h26;
    localparam logic [REG_ADDR_W-1:0] IDLE_ADDR      = 8'h2A;
    localparam logic [REG_ADDR_W-1:0] MODE_ADDR      = 8'h2B;

    typedef enum logic [1:0] {
        SRC_TX   = 2'd0,
        SRC_RX   = 2'd1,
        SRC_IDLE = 2'd2
    } src_e;
endpackage

// File: rtl/e1ii_regfile.sv
module e1ii_regfile
    import e1ii_pkg::*;
#(
    parameter int NUM_SLOTS = E1_SLOTS,
    parameter int DATA_W    = E1_SLOT_BITS,
    parameter int ADDR_W    = REG_ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 we,
    input  logic                 re,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_SLOTS-1:0] mask,
    output logic [DATA_W-1:0]    idle,
    output logic                 mode
);
    localparam int NUM_MASK = NUM_SLOTS / DATA_W;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] mask;
        logic [DATA_W-1:0]    idle;
        logic                 mode;
        logic [DATA_W-1:0]    rdata;
    } rf_state_t;

    rf_state_t state_d, state_q;
    logic [DATA_W-1:0] rd_val;

    // read decode works on the stored values, before any same-cycle write
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_MASK; i++) begin
            if (addr == MASK_BASE_ADDR + ADDR_W'(i)) begin
                rd_val = state_q.mask[i*DATA_W +: DATA_W];
            end
        end
        if (addr == IDLE_ADDR) begin
            rd_val = state_q.idle;
        end
        if (addr == MODE_ADDR) begin
            rd_val = {{(DATA_W-1){1'b0}}, state_q.mode};
        end
    end

    always_comb begin
        state_d = state_q;
        if (we) begin
            for (int i = 0; i < NUM_MASK; i++) begin
                if (addr == MASK_BASE_ADDR + ADDR_W'(i)) begin
                    state_d.mask[i*DATA_W +: DATA_W] = wdata;
                end
            end
            if (addr == IDLE_ADDR) begin
                state_d.idle = wdata;
            end
            if (addr == MODE_ADDR) begin
                state_d.mode = wdata[0];
            end
        end
        if (re) begin
            state_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata = state_q.rdata;
    assign mask  = state_q.mask;
    assign idle  = state_q.idle;
    assign mode  = state_q.mode;
endmodule

// File: rtl/e1ii_frame_counter.sv
module e1ii_frame_counter
    import e1ii_pkg::*;
#(
    parameter int NUM_SLOTS = E1_SLOTS,
    parameter int SLOT_BITS = E1_SLOT_BITS,
    localparam int TS_W     = $clog2(NUM_SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [TS_W-1:0]  cur_ts,
    output logic [BIT_W-1:0] cur_bit
);
    localparam logic [TS_W-1:0]  LAST_TS  = TS_W'(NUM_SLOTS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [BIT_W-1:0] bitpos;
    } pos_t;

    pos_t state_d, state_q;
    pos_t cur;

    always_comb begin
        // sync overrides the running position in the same cycle
        cur = fsync ? '0 : state_q;
        state_d = cur;
        if (cur.bitpos == LAST_BIT) begin
            state_d.bitpos = '0;
            state_d.ts     = (cur.ts == LAST_TS) ? '0 : cur.ts + TS_W'(1);
        end else begin
            state_d.bitpos = cur.bitpos + BIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cur_ts  = cur.ts;
    assign cur_bit = cur.bitpos;
endmodule

// File: rtl/e1ii_slot_mux.sv
module e1ii_slot_mux
    import e1ii_pkg::*;
#(
    parameter int NUM_SLOTS = E1_SLOTS,
    parameter int SLOT_BITS = E1_SLOT_BITS,
    localparam int TS_W     = $clog2(NUM_SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TS_W-1:0]      cur_ts,
    input  logic [BIT_W-1:0]     cur_bit,
    input  logic [NUM_SLOTS-1:0] mask,
    input  logic [SLOT_BITS-1:0] idle,
    input  logic                 mode,
    input  logic                 tx_bit,
    input  logic                 rx_bit,
    output logic                 bit_out,
    output src_e                 src,
    output logic [SLOT_BITS-1:0] snap_idle
);
    localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(SLOT_BITS - 1);

    typedef struct packed {
        logic                 sel;
        logic [SLOT_BITS-1:0] idle;
        logic                 mode;
    } snap_t;

    snap_t state_d, state_q;
    snap_t eff;
    logic [BIT_W-1:0] idle_idx;

    always_comb begin
        state_d = state_q;
        if (cur_bit == '0) begin
            // timeslot boundary: take the live settings and keep them
            eff.sel  = mask[cur_ts];
            eff.idle = idle;
            eff.mode = mode;
            state_d  = eff;
        end else begin
            eff = state_q;
        end

        if (eff.mode) begin
            src = eff.sel ? SRC_RX : SRC_TX;
        end else begin
            src = eff.sel ? SRC_IDLE : SRC_TX;
        end

        idle_idx = TOP_IDX - cur_bit;
        unique case (src)
            SRC_RX:   bit_out = rx_bit;
            SRC_IDLE: bit_out = eff.idle[idle_idx];
            default:  bit_out = tx_bit;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign snap_idle = state_q.idle;
endmodule

// File: rtl/e1_idle_inserter.sv
module e1_idle_inserter
    import e1ii_pkg::*;
#(
    parameter int NUM_SLOTS = E1_SLOTS,
    parameter int SLOT_BITS = E1_SLOT_BITS,
    parameter int ADDR_W    = REG_ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync,
    input  logic                 tx_ser_in,
    input  logic                 rx_ser_in,
    output logic                 ser_out,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [SLOT_BITS-1:0] reg_wdata,
    input  logic                 reg_we,
    input  logic                 reg_re,
    output logic [SLOT_BITS-1:0] reg_rdata
);
    localparam int TS_W  = $clog2(NUM_SLOTS);
    localparam int BIT_W = $clog2(SLOT_BITS);

    typedef struct packed {
        logic ser;
    } out_state_t;

    logic [NUM_SLOTS-1:0] cfg_mask;
    logic [SLOT_BITS-1:0] cfg_idle;
    logic                 cfg_mode;
    logic [TS_W-1:0]      cur_ts;
    logic [BIT_W-1:0]     cur_bit;
    logic                 mux_bit;
    src_e                 mux_src;
    logic [SLOT_BITS-1:0] snap_idle;
    out_state_t           state_d, state_q;

    e1ii_regfile #(
        .NUM_SLOTS (NUM_SLOTS),
        .DATA_W    (SLOT_BITS),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .we    (reg_we),
        .re    (reg_re),
        .rdata (reg_rdata),
        .mask  (cfg_mask),
        .idle  (cfg_idle),
        .mode  (cfg_mode)
    );

    e1ii_frame_counter #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_BITS (SLOT_BITS)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync   (fsync),
        .cur_ts  (cur_ts),
        .cur_bit (cur_bit)
    );

    e1ii_slot_mux #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_BITS (SLOT_BITS)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_ts    (cur_ts),
        .cur_bit   (cur_bit),
        .mask      (cfg_mask),
        .idle      (cfg_idle),
        .mode      (cfg_mode),
        .tx_bit    (tx_ser_in),
        .rx_bit    (rx_ser_in),
        .bit_out   (mux_bit),
        .src       (mux_src),
        .snap_idle (snap_idle)
    );

    always_comb begin
        state_d     = state_q;
        state_d.ser = mux_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ser_out = state_q.ser;
endmodule

// File: rtl/e1ii_checker.sv
module e1ii_checker
    import e1ii_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       fsync,
    input logic       tx_ser_in,
    input logic       rx_ser_in,
    input logic       ser_out,
    input logic [7:0] reg_addr,
    input logic       reg_re,
    input logic [7:0] reg_rdata,
    input logic [4:0] cur_ts,
    input logic [2:0] cur_bit,
    input src_e       mux_src,
    input logic [7:0] snap_idle
);
    // R1: bit position steps by one inside a timeslot
    a_r1_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bit != 3'd7) |=> (fsync || cur_bit == 3'($past(cur_bit) + 3'd1)));

    // R1: last bit rolls to the next timeslot, 31 wraps to 0
    a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bit == 3'd7) |=> (fsync || (cur_bit == 3'd0 && cur_ts == 5'($past(cur_ts) + 5'd1))));

    // R2: after a sync cycle the position is timeslot 0, bit 1
    a_r2_sync_align: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (fsync || (cur_ts == 5'd0 && cur_bit == 3'd1)));

    // R5 R8: transmit selection appears one clock later
    a_r8_tx_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_src == SRC_TX) |=> (ser_out == $past(tx_ser_in)));

    // R6 R8: loopback selection appears one clock later
    a_r6_rx_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_src == SRC_RX) |=> (ser_out == $past(rx_ser_in)));

    // R9: captured idle byte is held inside a timeslot
    a_r9_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bit != 3'd0) |=> $stable(snap_idle));

    // R10: unmapped addresses read as zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && (reg_addr < 8'h26 || reg_addr > 8'h2B)) |=> (reg_rdata == 8'h00));

    // R10: read data holds without a read
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata));
endmodule

bind e1_idle_inserter e1ii_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .tx_ser_in (tx_ser_in),
    .rx_ser_in (rx_ser_in),
    .ser_out   (ser_out),
    .reg_addr  (reg_addr),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata),
    .cur_ts    (cur_ts),
    .cur_bit   (cur_bit),
    .mux_src   (mux_src),
    .snap_idle (snap_idle)
);

// File: tb/tb_e1_idle_inserter.sv
module tb_e1_idle_inserter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       tx_ser_in = 1'b0;
    logic       rx_ser_in = 1'b0;
    logic       ser_out;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [7:0] reg_rdata;

    always #4 clk = ~clk;   // 125 MHz

    e1_idle_inserter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .tx_ser_in (tx_ser_in),
        .rx_ser_in (rx_ser_in),
        .ser_out   (ser_out),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string req = "R11";

    // behavioural reference state
    int         m_pos = 0;
    logic [7:0] m_regs [6];      // 0x26..0x2B
    logic       m_sel = 1'b0;
    logic       m_mode = 1'b0;
    logic [7:0] m_idle = 8'h00;
    logic       exp_out = 1'b0;
    logic [7:0] exp_rd = 8'h00;

    task automatic check_outputs();
        n_checks++;
        if (ser_out !== exp_out) begin
            n_fails++;
            $display("FAIL %s ser_out actual=%b expected=%b t=%0t", req, ser_out, exp_out, $time);
        end
        n_checks++;
        if (reg_rdata !== exp_rd) begin
            n_fails++;
            $display("FAIL %s reg_rdata actual=%h expected=%h t=%0t", req, reg_rdata, exp_rd, $time);
        end
    endtask

    // called at a falling edge: check, drive, predict, move to next falling edge
    task automatic step(input logic fs, input logic tx, input logic rx,
                        input logic we, input logic re,
                        input logic [7:0] addr, input logic [7:0] wd);
        int b;
        int t;
        check_outputs();
        fsync = fs; tx_ser_in = tx; rx_ser_in = rx;
        reg_we = we; reg_re = re; reg_addr = addr; reg_wdata = wd;
        if (fs) m_pos = 0;
        b = m_pos % 8;
        t = m_pos / 8;
        if (b == 0) begin
            m_sel  = m_regs[t / 8][t % 8];
            m_idle = m_regs[4];
            m_mode = m_regs[5][0];
        end
        if (m_mode) exp_out = m_sel ? rx : tx;
        else        exp_out = m_sel ? m_idle[7 - b] : tx;
        m_pos = (m_pos + 1) % 256;
        if (re) begin
            if (addr >= 8'h26 && addr <= 8'h2B) exp_rd = m_regs[addr - 8'h26];
            else                                exp_rd = 8'h00;
        end
        if (we && addr >= 8'h26 && addr <= 8'h2B) begin
            if (addr == 8'h2B) m_regs[5] = {7'b0, wd[0]};
            else               m_regs[addr - 8'h26] = wd;
        end
        @(negedge clk);
    endtask

    task automatic run_random(input int cycles, input int sync_every);
        for (int i = 0; i < cycles; i++) begin
            step((sync_every > 0) && (i % sync_every == 0),
                 1'($urandom), 1'($urandom), 1'b0, 1'b0, 8'h00, 8'h00);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        step(1'b0, 1'($urandom), 1'($urandom), 1'b1, 1'b0, a, d);
    endtask

    task automatic rd(input logic [7:0] a);
        step(1'b0, 1'($urandom), 1'($urandom), 1'b0, 1'b1, a, 8'h00);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1D1E_C0DE));
        for (int i = 0; i < 6; i++) m_regs[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R11: outputs are zero while reset is held
        req = "R11";
        check_outputs();
        rst_n = 1'b1;

        // R7 R10: reset contents read back as zero, traffic passes through
        req = "R7 R10";
        for (int a = 8'h26; a <= 8'h2B; a++) rd(8'(a));
        run_random(100, 0);

        // R5 R8 R2: passthrough with aligned frames
        req = "R5 R8 R2";
        run_random(300, 256);

        // R3 R4: channel map and idle byte order
        req = "R3 R4";
        wr(8'h26, 8'h01);   // timeslot 0
        wr(8'h27, 8'h80);   // timeslot 15
        wr(8'h28, 8'h5A);
        wr(8'h29, 8'h80);   // timeslot 31
        wr(8'h2A, 8'hA5);
        run_random(600, 256);
        wr(8'h2A, 8'h3C);
        wr(8'h26, 8'hFF);
        run_random(300, 256);

        // R1: free-running wrap with no sync
        req = "R1";
        run_random(700, 0);

        // R6: loopback mode, idle byte never sent
        req = "R6";
        wr(8'h2B, 8'h01);
        run_random(600, 256);
        wr(8'h27, 8'h0F);
        run_random(300, 0);
        wr(8'h2B, 8'hFE);   // bit 0 clear: back to idle mode
        run_random(100, 0);

        // R9: writes at random offsets inside timeslots
        req = "R9";
        for (int i = 0; i < 2000; i++) begin
            if ($urandom % 9 == 0)
                step(1'b0, 1'($urandom), 1'($urandom), 1'b1, 1'($urandom),
                     8'(8'h26 + $urandom % 6), 8'($urandom));
            else
                step(1'b0, 1'($urandom), 1'($urandom), 1'b0, 1'b0, 8'h00, 8'h00);
        end

        // R2: sync at arbitrary positions realigns the frame
        req = "R2";
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 97) == 0, 1'($urandom), 1'($urandom), 1'b0, 1'b0, 8'h00, 8'h00);
        end

        // R10: read-back, unmapped addresses, hold, read during write
        req = "R10";
        for (int a = 8'h26; a <= 8'h2B; a++) rd(8'(a));
        rd(8'h00); rd(8'h25); rd(8'h2C); rd(8'hFF);
        rd(8'h28);
        run_random(10, 0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h29, 8'hC3);
        rd(8'h29);
        run_random(5, 0);

        check_outputs();
        finish_run();
    end
endmodule